// File: doc/BRIEF.md
# Synchronous Burst Write Timing Generator

This block drives the host side of a synchronous external memory bus for one burst write at a time. A start pulse begins an access. The block then produces a divided bus clock, a one-cycle data strobe for each beat, and the data word for that beat. All timing parameters are counted in functional-clock ticks. Internally the block runs from `clk_i`, which is twice the tick rate, so each tick spans two cycles, called steps. Step resolution lets the block launch a beat on a falling bus-clock edge that lies in the middle of a tick. The cycle after the accepting edge is step 0, and tick `t` begins at step `2t`.

Beats are placed so that the receiver can always capture data on rising bus-clock edges. In divide-by-1 operation, every beat after the first is pushed half a tick late, onto the falling edge. Three timing rules and a non-zero length are checked all the time on the live configuration inputs. A start request is refused while any of these rule flags is set. The configuration is captured when a start is accepted, so it may change while a burst runs.

Top module: `sbw_burst_writer`

## Requirements
- R1: `rule_err_o[0]` is set exactly when `page_time_i` differs from `clk_div_i + 1`.
- R2: `rule_err_o[1]` is set exactly when `cyc_time_i < clk_act_i` or `(cyc_time_i - clk_act_i)` is not a multiple of `clk_div_i + 1`.
- R3: `rule_err_o[2]` is set exactly when `clk_div_i` is non-zero and the non-negative residue of `(acc_time_i - clk_act_i)` modulo `clk_div_i + 1` equals `clk_div_i`.
- R4: `rule_err_o[3]` is set exactly when `burst_len_i` is zero.
- R5: While any bit of `rule_err_o` is set, `start_i` is refused: `busy_o`, `bclk_o` and `dstb_o` stay low and `data_o` keeps its value.
- R6: With n = divider + 1, `bclk_o` is low before step `2*act`. From that step until step `2*cyc` it has a period of `2n` steps. It is high for the first step of each period when n = 1, and for the first `2*ceil(n/2)` steps otherwise. It is low from step `2*cyc` onward and whenever the block is idle.
- R7: The first beat launches at step 0 in direct mode (`mux_mode_i`=0), or at step `2*mux_data_time_i` in multiplexed mode (`mux_mode_i`=1). At a launch, `dstb_o` is high for that step and `data_o` shows the `wr_data_i` value present at the launching edge.
- R8: Beat i (counting from 0, i ≥ 1) launches at step `2*(acc+1) + 2*page*(i-1)`, plus one more step when the divider is 0, so that it falls on a falling bus-clock edge.
- R9: Exactly `burst_len_i` beats are launched, except that no beat launches at or after step `2*cyc`. Between launches, `data_o` holds its value.
- R10: `done_o` is high for exactly one cycle, at step `2*cyc`. `busy_o` is high from step 0 through that step and low in the next cycle.
- R11: A start pulse during a burst is ignored and does not disturb the burst in progress.
- R12: After reset, `busy_o`, `done_o`, `bclk_o` and `dstb_o` are low and `data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Step clock, twice the tick rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a burst |
| mux_mode_i | input | 1 | 0 = direct data bus, 1 = multiplexed address/data bus |
| burst_len_i | input | LEN_W | Number of beats |
| clk_div_i | input | DIV_W | Bus clock divider (ratio = value + 1) |
| clk_act_i | input | TW | Tick of the first rising bus-clock edge |
| cyc_time_i | input | TW | Tick at which the access ends |
| acc_time_i | input | TW | Write access time; second beat at this + 1 |
| mux_data_time_i | input | TW | First-beat tick in multiplexed mode |
| page_time_i | input | TW | Ticks between later beats |
| wr_data_i | input | DATA_W | Word for the next beat |
| bclk_o | output | 1 | Divided bus clock |
| data_o | output | DATA_W | Bus data |
| dstb_o | output | 1 | One-step strobe marking a new beat |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle pulse at the end of the access |
| rule_err_o | output | 4 | Rule violation flags, bits as in R1 to R4 |

## Verification
A step counter that is off by one shows in the very next cycle. The bus-clock edges move relative to the computed schedule, and `done_o` arrives early or late. A wrong beat pointer or next-launch value shows at the next scheduled launch: the strobe is missing or comes at the wrong step, or `data_o` carries the wrong word. The bench therefore compares the bus clock, strobe, busy and done against the arithmetic schedule at every step of every burst, over a sweep of all dividers, several activation times, both bus modes and truncated bursts. The rule flags are combinational, so any error in them is visible at once; the bench sweeps every combination of a small parameter range.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  localparam int ERR_W      = 4;
  localparam int ERR_PAGE   = 0;
  localparam int ERR_CYCLE  = 1;
  localparam int ERR_ACCESS = 2;
  localparam int ERR_LEN    = 3;

  typedef enum logic {
    BUS_DIRECT = 1'b0,
    BUS_MUXED  = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/sbw_rule_check.sv
module sbw_rule_check
  import sbw_pkg::*;
#(
  parameter int TW    = 6,
  parameter int LEN_W = 4,
  parameter int DIV_W = 2
) (
  input  logic [DIV_W-1:0] div_i,
  input  logic [TW-1:0]    page_i,
  input  logic [TW-1:0]    act_i,
  input  logic [TW-1:0]    cyc_i,
  input  logic [TW-1:0]    acc_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [ERR_W-1:0] err_o
);
  logic [TW-1:0] ratio;
  logic [TW-1:0] cyc_rem;
  logic [TW-1:0] back_rem;
  logic [TW-1:0] acc_rem;

  always_comb begin
    ratio    = TW'(div_i) + TW'(1);
    cyc_rem  = (cyc_i - act_i) % ratio;
    back_rem = '0;
    if (acc_i >= act_i) begin
      acc_rem = (acc_i - act_i) % ratio;
    end else begin
      // residue of a negative gap, folded to 0..ratio-1
      back_rem = (act_i - acc_i) % ratio;
      acc_rem  = (back_rem == '0) ? '0 : ratio - back_rem;
    end
    err_o             = '0;
    err_o[ERR_PAGE]   = (page_i != ratio);
    err_o[ERR_CYCLE]  = (cyc_i < act_i) || (cyc_rem != '0);
    err_o[ERR_ACCESS] = (div_i != '0) && (acc_rem == TW'(div_i));
    err_o[ERR_LEN]    = (len_i == '0);
  end
endmodule

// File: rtl/sbw_step_ctrl.sv
module sbw_step_ctrl #(
  parameter int TW = 6,
  localparam int HW = TW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          err_any_i,
  input  logic [TW-1:0] cyc_i,
  output logic          start_acc_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          busy_nxt_o,
  output logic [HW-1:0] step_nxt_o
);
  logic          busy_q;
  logic [HW-1:0] step_q;
  logic [HW-1:0] end_step;
  logic          run_on;

  always_comb begin
    end_step    = {cyc_i, 1'b0};
    start_acc_o = start_i && !busy_q && !err_any_i;
    done_o      = busy_q && (step_q == end_step);
    run_on      = busy_q && !done_o;
    busy_nxt_o  = start_acc_o || run_on;
    if (start_acc_o)  step_nxt_o = '0;
    else if (run_on)  step_nxt_o = step_q + 1'b1;
    else              step_nxt_o = step_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= '0;
    end else begin
      busy_q <= busy_nxt_o;
      step_q <= step_nxt_o;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/sbw_bclk_gen.sv
module sbw_bclk_gen #(
  parameter int TW    = 6,
  parameter int DIV_W = 2,
  localparam int HW   = TW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_nxt_i,
  input  logic [HW-1:0]    step_nxt_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [TW-1:0]    act_i,
  input  logic [TW-1:0]    cyc_i,
  output logic             bclk_o
);
  logic [HW-1:0]    act_step;
  logic [HW-1:0]    end_step;
  logic [HW-1:0]    period;
  logic [HW-1:0]    high_len;
  logic [HW-1:0]    offset;
  logic [HW-1:0]    phase;
  logic [DIV_W-1:0] half_ticks;
  logic             bclk_nxt;
  logic             bclk_q;

  always_comb begin
    act_step   = {act_i, 1'b0};
    end_step   = {cyc_i, 1'b0};
    period     = HW'({div_i, 1'b0}) + HW'(2);
    half_ticks = (div_i >> 1) + DIV_W'(1);
    // divide-by-1 needs a half-tick high phase; otherwise whole ticks, long high
    high_len   = (div_i == '0) ? HW'(1) : HW'({half_ticks, 1'b0});
    offset     = step_nxt_i - act_step;
    phase      = offset % period;
    bclk_nxt   = busy_nxt_i && (step_nxt_i >= act_step) &&
                 (step_nxt_i < end_step) && (phase < high_len);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_q <= 1'b0;
    else         bclk_q <= bclk_nxt;
  end

  assign bclk_o = bclk_q;
endmodule

// File: rtl/sbw_beat_sched.sv
module sbw_beat_sched #(
  parameter int DATA_W = 16,
  parameter int TW     = 6,
  parameter int LEN_W  = 4,
  parameter int DIV_W  = 2,
  localparam int HW    = TW + 1,
  localparam int NW    = TW + LEN_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_acc_i,
  input  logic              busy_nxt_i,
  input  logic [HW-1:0]     step_nxt_i,
  input  logic              mux_i,
  input  logic [TW-1:0]     dmux_i,
  input  logic [TW-1:0]     acc_i,
  input  logic [TW-1:0]     page_i,
  input  logic [TW-1:0]     cyc_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              dstb_o
);
  logic [LEN_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  cnt_eff;
  logic [NW-1:0]     next_q;
  logic [NW-1:0]     next_eff;
  logic [NW-1:0]     first_step;
  logic [NW-1:0]     second_step;
  logic [NW-1:0]     page_step;
  logic              launch;
  logic [DATA_W-1:0] data_q;
  logic              dstb_q;

  always_comb begin
    first_step  = mux_i ? NW'({dmux_i, 1'b0}) : '0;
    // later beats in divide-by-1 slip half a tick onto the falling edge
    second_step = NW'({HW'(acc_i) + HW'(1), 1'b0}) +
                  ((div_i == '0) ? NW'(1) : NW'(0));
    page_step   = NW'({page_i, 1'b0});
    next_eff    = start_acc_i ? first_step : next_q;
    cnt_eff     = start_acc_i ? '0 : cnt_q;
    launch      = busy_nxt_i && (NW'(step_nxt_i) == next_eff) &&
                  (cnt_eff < len_i) && (step_nxt_i < {cyc_i, 1'b0});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      next_q <= '0;
      data_q <= '0;
      dstb_q <= 1'b0;
    end else begin
      dstb_q <= launch;
      if (launch) begin
        data_q <= wr_data_i;
        cnt_q  <= cnt_eff + 1'b1;
        next_q <= (cnt_eff == '0) ? second_step : next_eff + page_step;
      end else if (start_acc_i) begin
        cnt_q  <= '0;
        next_q <= first_step;
      end
    end
  end

  assign data_o = data_q;
  assign dstb_o = dstb_q;
endmodule

// File: rtl/sbw_burst_writer.sv
module sbw_burst_writer
  import sbw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TW     = 6,
  parameter int LEN_W  = 4,
  parameter int DIV_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mux_mode_i,
  input  logic [LEN_W-1:0]  burst_len_i,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic [TW-1:0]     clk_act_i,
  input  logic [TW-1:0]     cyc_time_i,
  input  logic [TW-1:0]     acc_time_i,
  input  logic [TW-1:0]     mux_data_time_i,
  input  logic [TW-1:0]     page_time_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              bclk_o,
  output logic [DATA_W-1:0] data_o,
  output logic              dstb_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ERR_W-1:0]  rule_err_o
);
  localparam int HW = TW + 1;

  typedef struct packed {
    logic             mux;
    logic [LEN_W-1:0] len;
    logic [DIV_W-1:0] div;
    logic [TW-1:0]    act;
    logic [TW-1:0]    cyc;
    logic [TW-1:0]    acc;
    logic [TW-1:0]    dmux;
    logic [TW-1:0]    page;
  } cfg_t;

  cfg_t          cfg_live;
  cfg_t          cfg_q;
  cfg_t          cfg_eff;
  logic          start_acc;
  logic          busy_nxt;
  logic [HW-1:0] step_nxt;
  logic [ERR_W-1:0] err;

  always_comb begin
    cfg_live.mux  = (bus_mode_e'(mux_mode_i) == BUS_MUXED);
    cfg_live.len  = burst_len_i;
    cfg_live.div  = clk_div_i;
    cfg_live.act  = clk_act_i;
    cfg_live.cyc  = cyc_time_i;
    cfg_live.acc  = acc_time_i;
    cfg_live.dmux = mux_data_time_i;
    cfg_live.page = page_time_i;
    cfg_eff       = start_acc ? cfg_live : cfg_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cfg_q <= '0;
    else if (start_acc) cfg_q <= cfg_live;
  end

  sbw_rule_check #(.TW(TW), .LEN_W(LEN_W), .DIV_W(DIV_W)) i_rules (
    .div_i  (clk_div_i),
    .page_i (page_time_i),
    .act_i  (clk_act_i),
    .cyc_i  (cyc_time_i),
    .acc_i  (acc_time_i),
    .len_i  (burst_len_i),
    .err_o  (err)
  );

  // end-of-access compare uses captured config only, so no loop through start_acc
  sbw_step_ctrl #(.TW(TW)) i_steps (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .err_any_i   (|err),
    .cyc_i       (cfg_q.cyc),
    .start_acc_o (start_acc),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .busy_nxt_o  (busy_nxt),
    .step_nxt_o  (step_nxt)
  );

  sbw_bclk_gen #(.TW(TW), .DIV_W(DIV_W)) i_bclk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .busy_nxt_i (busy_nxt),
    .step_nxt_i (step_nxt),
    .div_i      (cfg_eff.div),
    .act_i      (cfg_eff.act),
    .cyc_i      (cfg_eff.cyc),
    .bclk_o     (bclk_o)
  );

  sbw_beat_sched #(.DATA_W(DATA_W), .TW(TW), .LEN_W(LEN_W), .DIV_W(DIV_W)) i_beats (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_acc_i (start_acc),
    .busy_nxt_i  (busy_nxt),
    .step_nxt_i  (step_nxt),
    .mux_i       (cfg_eff.mux),
    .dmux_i      (cfg_eff.dmux),
    .acc_i       (cfg_eff.acc),
    .page_i      (cfg_eff.page),
    .cyc_i       (cfg_eff.cyc),
    .div_i       (cfg_eff.div),
    .len_i       (cfg_eff.len),
    .wr_data_i   (wr_data_i),
    .data_o      (data_o),
    .dstb_o      (dstb_o)
  );

  assign rule_err_o = err;
endmodule

// File: rtl/sbw_burst_writer_chk.sv
module sbw_burst_writer_chk
  import sbw_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              bclk_o,
  input logic              dstb_o,
  input logic [DATA_W-1:0] data_o,
  input logic [ERR_W-1:0]  rule_err_o
);
  p_refuse_on_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && rule_err_o != '0) |=> !busy_o);

  p_bclk_low_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !bclk_o);

  p_bclk_low_at_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bclk_o);

  p_stb_in_access_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dstb_o |-> busy_o);

  p_data_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dstb_o |-> $stable(data_o));

  p_no_beat_at_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !dstb_o);

  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_ends_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  p_done_needs_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  p_busy_holds_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

bind sbw_burst_writer sbw_burst_writer_chk #(.DATA_W(DATA_W)) i_sbw_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .bclk_o     (bclk_o),
  .dstb_o     (dstb_o),
  .data_o     (data_o),
  .rule_err_o (rule_err_o)
);

// File: tb/test_sbw_burst_writer.sv
module test_sbw_burst_writer;
  localparam int DATA_W = 16;
  localparam int TW     = 6;
  localparam int LEN_W  = 4;
  localparam int DIV_W  = 2;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic              mux_mode_i = 1'b0;
  logic [LEN_W-1:0]  burst_len_i = '0;
  logic [DIV_W-1:0]  clk_div_i = '0;
  logic [TW-1:0]     clk_act_i = '0;
  logic [TW-1:0]     cyc_time_i = '0;
  logic [TW-1:0]     acc_time_i = '0;
  logic [TW-1:0]     mux_data_time_i = '0;
  logic [TW-1:0]     page_time_i = '0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic              bclk_o;
  logic [DATA_W-1:0] data_o;
  logic              dstb_o;
  logic              busy_o;
  logic              done_o;
  logic [3:0]        rule_err_o;

  int n_chk = 0;
  int n_bad = 0;
  int burst_id = 0;
  int beat_step [16];
  bit beat_on [16];

  always #10 clk_i = ~clk_i;

  sbw_burst_writer #(.DATA_W(DATA_W), .TW(TW), .LEN_W(LEN_W), .DIV_W(DIV_W)) i_sbw_burst_writer (
    .clk_i, .rst_ni, .start_i, .mux_mode_i, .burst_len_i, .clk_div_i, .clk_act_i,
    .cyc_time_i, .acc_time_i, .mux_data_time_i, .page_time_i, .wr_data_i,
    .bclk_o, .data_o, .dstb_o, .busy_o, .done_o, .rule_err_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input int id, input int k);
    return DATA_W'(32'h1000 + id * 32 + k);
  endfunction

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic run_burst(input int dv, input int ac, input bit mx, input int ln, input int m);
    int n, wa, dm, cy, pb, kseen, nexp, idx;
    bit ebclk, estb;
    n  = dv + 1;
    pb = n;
    wa = ac + n;
    dm = ac + 1;
    cy = ac + n * m;
    nexp = 0;
    for (int i = 0; i < 16; i++) begin
      beat_on[i] = 1'b0;
      beat_step[i] = (i == 0) ? (mx ? 2 * dm : 0)
                              : 2 * (wa + 1) + 2 * pb * (i - 1) + ((dv == 0) ? 1 : 0);
      if (i < ln && beat_step[i] < 2 * cy &&
          (i == 0 || (beat_on[i-1] && beat_step[i] > beat_step[i-1]))) begin
        beat_on[i] = 1'b1;
        nexp++;
      end
    end
    burst_id++;
    kseen = 0;
    @(negedge clk_i);
    mux_mode_i      = mx;
    burst_len_i     = LEN_W'(ln);
    clk_div_i       = DIV_W'(dv);
    clk_act_i       = TW'(ac);
    cyc_time_i      = TW'(cy);
    acc_time_i      = TW'(wa);
    mux_data_time_i = TW'(dm);
    page_time_i     = TW'(pb);
    wr_data_i       = pat(burst_id, 0);
    start_i         = 1'b1;
    #1;
    check(rule_err_o == 4'b0, "R1 legal config flags", int'(rule_err_o), 0);
    for (int s = 0; s <= 2 * cy; s++) begin
      @(negedge clk_i);
      // R11: a start pulse at step 3 must leave the running burst untouched
      start_i = (s == 3);
      if (s >= 2 * ac && s < 2 * cy)
        ebclk = ((s - 2 * ac) % (2 * n)) < ((n == 1) ? 1 : 2 * ((n + 1) / 2));
      else
        ebclk = 1'b0;
      estb = 1'b0;
      idx = 0;
      for (int i = 0; i < 16; i++)
        if (beat_on[i] && beat_step[i] == s) begin
          estb = 1'b1;
          idx = i;
        end
      check(bclk_o == ebclk, "R6 bus clock", int'(bclk_o), int'(ebclk));
      check(dstb_o == estb, (idx == 0) ? "R7 first beat strobe" : "R8 later beat strobe",
            int'(dstb_o), int'(estb));
      check(busy_o == 1'b1, "R10 busy during access", int'(busy_o), 1);
      check(done_o == (s == 2 * cy), "R10 done pulse", int'(done_o), int'(s == 2 * cy));
      if (estb) begin
        check(data_o == pat(burst_id, idx), "R7 launched data", int'(data_o),
              int'(pat(burst_id, idx)));
        kseen++;
        wr_data_i = pat(burst_id, kseen);
      end else if (kseen > 0) begin
        check(data_o == pat(burst_id, kseen - 1), "R9 data held", int'(data_o),
              int'(pat(burst_id, kseen - 1)));
      end
      if (dstb_o) begin
        if (!estb) kseen++;
      end
    end
    @(negedge clk_i);
    check(busy_o == 1'b0, "R10 idle after done", int'(busy_o), 0);
    check(done_o == 1'b0, "R10 done single cycle", int'(done_o), 0);
    check(bclk_o == 1'b0, "R6 clock low when idle", int'(bclk_o), 0);
    check(kseen == nexp, "R9 beat count", kseen, nexp);
  endtask

  task automatic try_refused(input int dv, input int ac, input int cy, input int wa,
                             input int pb, input int ln);
    logic [DATA_W-1:0] held;
    @(negedge clk_i);
    clk_div_i   = DIV_W'(dv);
    clk_act_i   = TW'(ac);
    cyc_time_i  = TW'(cy);
    acc_time_i  = TW'(wa);
    page_time_i = TW'(pb);
    burst_len_i = LEN_W'(ln);
    mux_mode_i  = 1'b0;
    wr_data_i   = 16'hdead;
    held        = data_o;
    start_i     = 1'b1;
    #1;
    check(rule_err_o != 4'b0, "R5 config flagged", int'(rule_err_o), 1);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk_i);
      start_i = 1'b1;
      check(busy_o == 1'b0, "R5 start refused busy", int'(busy_o), 0);
      check(bclk_o == 1'b0, "R5 no bus clock", int'(bclk_o), 0);
      check(dstb_o == 1'b0, "R5 no strobe", int'(dstb_o), 0);
      check(data_o == held, "R5 data untouched", int'(data_o), int'(held));
    end
    start_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int n, r, eacc;
    repeat (3) @(negedge clk_i);
    check(busy_o == 1'b0, "R12 reset busy", int'(busy_o), 0);
    check(bclk_o == 1'b0, "R12 reset bclk", int'(bclk_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(busy_o == 1'b0, "R12 busy after reset", int'(busy_o), 0);
    check(done_o == 1'b0, "R12 done after reset", int'(done_o), 0);
    check(dstb_o == 1'b0, "R12 strobe after reset", int'(dstb_o), 0);
    check(data_o == '0, "R12 data after reset", int'(data_o), 0);

    // rule flags, exhaustive over a small range
    for (int dv = 0; dv < 4; dv++)
      for (int pb = 0; pb < 8; pb++)
        for (int ac = 0; ac < 8; ac++)
          for (int cy = 0; cy < 8; cy++)
            for (int wa = 0; wa < 8; wa++)
              for (int ln = 0; ln < 2; ln++) begin
                clk_div_i   = DIV_W'(dv);
                page_time_i = TW'(pb);
                clk_act_i   = TW'(ac);
                cyc_time_i  = TW'(cy);
                acc_time_i  = TW'(wa);
                burst_len_i = LEN_W'(ln);
                #1;
                n = dv + 1;
                r = (((wa - ac) % n) + n) % n;
                eacc = (dv != 0 && r == dv) ? 1 : 0;
                check(rule_err_o[0] == (pb != n), "R1 page rule",
                      int'(rule_err_o[0]), int'(pb != n));
                check(rule_err_o[1] == (cy < ac || ((cy - ac) % n) != 0), "R2 cycle rule",
                      int'(rule_err_o[1]), int'(cy < ac || ((cy - ac) % n) != 0));
                check(rule_err_o[2] == eacc[0], "R3 access rule", int'(rule_err_o[2]), eacc);
                check(rule_err_o[3] == (ln == 0), "R4 length rule",
                      int'(rule_err_o[3]), int'(ln == 0));
              end

    try_refused(1, 0, 4, 2, 3, 2);   // page
    try_refused(2, 1, 6, 4, 3, 2);   // cycle
    try_refused(1, 0, 4, 1, 2, 2);   // access
    try_refused(0, 0, 4, 1, 1, 0);   // length

    for (int dv = 0; dv < 4; dv++)
      for (int ac = 0; ac < 4; ac++)
        for (int mx = 0; mx < 2; mx++) begin
          run_burst(dv, ac, mx[0], 1, 3);
          run_burst(dv, ac, mx[0], 3, 5);
        end
    // truncated bursts: later beats fall past the cycle end
    for (int dv = 0; dv < 4; dv++) run_burst(dv, 1, 1'b0, 8, 3);

    summary();
    $finish;
  end
endmodule